// File: doc/BRIEF.md
# Dual-Source Bus Ready Synchronizer

This block merges two asynchronous "transfer done" indications from the system bus into one processor ready signal. Each indication arrives together with its own active-low enable. A source counts only while its enable is low. The qualified request is the OR of the two gated sources. It is carried into the processor clock domain and presented on `ready`.

A static strap, `two_stage_n`, selects the synchronization depth:

- **Two stages (strap low):** a rising-edge capture flop first samples the request. A falling-edge ready register then takes the captured value half a clock later.
- **One stage (strap high):** the falling-edge ready register samples the request directly.

The ready register is a two-state machine. Its states are `RDY_DEASSERTED` and `RDY_ASSERTED`. It follows its selected source at every falling edge:

- The "raise" transition takes `RDY_DEASSERTED` to `RDY_ASSERTED` when the source is 1.
- The "drop" transition takes `RDY_ASSERTED` to `RDY_DEASSERTED` when the source is 0.
- Otherwise the state holds.

Because the register moves only on falling edges, an asserted `ready` is held for at least one full clock period. That covers the processor's hold window.

Top module: `bus_ready_sync`

## Requirements
- R1: The internal request is (rdy_a AND NOT en_a_n) OR (rdy_b AND NOT en_b_n); either valid source alone can raise `ready`.
- R2: While en_a_n is 1, rdy_a has no effect on `ready`.
- R3: While en_b_n is 1, rdy_b has no effect on `ready`.
- R4: With two_stage_n = 0, the request is captured at a rising edge. `ready` takes that captured value at the following falling edge.
- R5: With two_stage_n = 1, `ready` takes the request directly at each falling edge.
- R6: `ready` changes only at falling clock edges, so any level it shows is held for a full clock period.
- R7: While rst (active high, synchronous) is 1, the capture stage and `ready` are cleared to 0 (state `RDY_DEASSERTED`).
- R8: two_stage_n is a static strap that is changed only while rst is 1. After each reset the mode it selects is applied from the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy_a | input | 1 | Ready indication from source A, active high |
| rdy_b | input | 1 | Ready indication from source B, active high |
| en_a_n | input | 1 | Active-low enable qualifying rdy_a |
| en_b_n | input | 1 | Active-low enable qualifying rdy_b |
| two_stage_n | input | 1 | Strap: 0 selects two stages, 1 selects one stage |
| ready | output | 1 | Synchronized ready to the processor |

## Verification
A stuck or stale capture flop shows up at the ports one clock late in two-stage mode. It appears as a `ready` level that disagrees with the request driven one cycle earlier. A wrong ready state is visible in the same cycle, right after the falling edge. A `ready` that moves on the rising edge is caught by sampling just after that edge and comparing with the previous level. Gating faults show as a raised `ready` while the only asserted source has its enable high.

// File: rtl/brs_pkg.sv
package brs_pkg;
    typedef enum logic {
        RDY_DEASSERTED = 1'b0,
        RDY_ASSERTED   = 1'b1
    } rdy_state_e;
endpackage

// File: rtl/brs_qualify.sv
module brs_qualify #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] src_rdy,
    input  logic [N_SRC-1:0] src_en_n,
    output logic             req
);
    logic [N_SRC-1:0] gated;

    // R1: each source counts only while its own enable is low
    for (genvar i = 0; i < N_SRC; i++) begin : g_gate
        assign gated[i] = src_rdy[i] & ~src_en_n[i];
    end

    assign req = |gated;
endmodule

// File: rtl/brs_capture.sv
module brs_capture #(
    parameter int PRE_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [PRE_STAGES-1:0] chain;

    for (genvar s = 0; s < PRE_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[s] <= 1'b0;
            end else begin
                chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = chain[PRE_STAGES-1];
endmodule

// File: rtl/bus_ready_sync.sv
module bus_ready_sync
    import brs_pkg::*;
#(
    parameter int N_SRC      = 2,
    parameter int PRE_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic rdy_a,
    input  logic rdy_b,
    input  logic en_a_n,
    input  logic en_b_n,
    input  logic two_stage_n,
    output logic ready
);
    localparam int SRC_A = 0;
    localparam int SRC_B = N_SRC - 1;

    logic [N_SRC-1:0] rdy_vec;
    logic [N_SRC-1:0] en_vec;
    logic             req;
    logic             cap_q;
    logic             src_sel;
    rdy_state_e       state_q;
    rdy_state_e       state_d;

    always_comb begin
        rdy_vec        = '0;
        en_vec         = '1;
        rdy_vec[SRC_A] = rdy_a;
        en_vec[SRC_A]  = en_a_n;
        rdy_vec[SRC_B] = rdy_b;
        en_vec[SRC_B]  = en_b_n;
    end

    brs_qualify #(.N_SRC(N_SRC)) u_qual (
        .src_rdy  (rdy_vec),
        .src_en_n (en_vec),
        .req      (req)
    );

    brs_capture #(.PRE_STAGES(PRE_STAGES)) u_cap (
        .clk (clk),
        .rst (rst),
        .d   (req),
        .q   (cap_q)
    );

    // R4/R5: strap picks the falling-edge register's source
    assign src_sel = two_stage_n ? req : cap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RDY_DEASSERTED: if (src_sel)  state_d = RDY_ASSERTED;
            RDY_ASSERTED:   if (!src_sel) state_d = RDY_DEASSERTED;
            default:        state_d = RDY_DEASSERTED;
        endcase
    end

    // R6/R7: state register on the falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            state_q <= RDY_DEASSERTED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RDY_ASSERTED: ready = 1'b1;
            default:      ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/bus_ready_sync_chk.sv
module bus_ready_sync_chk (
    input logic clk,
    input logic rst,
    input logic rdy_a,
    input logic rdy_b,
    input logic en_a_n,
    input logic en_b_n,
    input logic two_stage_n,
    input logic cap_q,
    input logic ready
);
    logic rst_d = 1'b0;
    logic req_p;

    assign req_p = (rdy_a & ~en_a_n) | (rdy_b & ~en_b_n);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst && rst_d) begin
            assert_reset_clear_R7: assert (!ready && !cap_q);
        end
    end

    assert_one_stage_R5: assert property (@(negedge clk) disable iff (rst)
        two_stage_n |=> (ready == $past(req_p)));

    assert_two_stage_R4: assert property (@(negedge clk) disable iff (rst)
        !two_stage_n |=> (ready == $past(cap_q)));

    assert_gated_off_R1: assert property (@(negedge clk) disable iff (rst)
        (two_stage_n && en_a_n && en_b_n) |=> !ready);

    assert_gate_a_R2: assert property (@(negedge clk) disable iff (rst)
        (two_stage_n && en_a_n && !rdy_b) |=> !ready);

    assert_gate_b_R3: assert property (@(negedge clk) disable iff (rst)
        (two_stage_n && en_b_n && !rdy_a) |=> !ready);

    always @(ready) begin
        if (!rst && rst_d == 1'b0 && $time > 0) begin
            assert_fall_only_R6: assert (clk == 1'b0);
        end
    end
endmodule

bind bus_ready_sync bus_ready_sync_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rdy_a       (rdy_a),
    .rdy_b       (rdy_b),
    .en_a_n      (en_a_n),
    .en_b_n      (en_b_n),
    .two_stage_n (two_stage_n),
    .cap_q       (cap_q),
    .ready       (ready)
);

// File: tb/test_bus_ready_sync.sv
`timescale 1ns/1ps
module test_bus_ready_sync;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rdy_a = 1'b0, rdy_b = 1'b0;
    logic en_a_n = 1'b1, en_b_n = 1'b1;
    logic two_stage_n = 1'b0;
    logic ready;

    int n_cmp = 0;
    int n_bad = 0;
    logic prev_req = 1'b0;
    logic last_rdy = 1'b0;
    int unsigned seed_val;

    always #4 clk = ~clk;

    bus_ready_sync i_bus_ready_sync (
        .clk(clk), .rst(rst), .rdy_a(rdy_a), .rdy_b(rdy_b),
        .en_a_n(en_a_n), .en_b_n(en_b_n),
        .two_stage_n(two_stage_n), .ready(ready)
    );

    function automatic logic ref_req(logic a, logic b, logic ea, logic eb);
        return (a & ~ea) | (b & ~eb);
    endfunction

    function automatic logic ref_ready(logic one_stage, logic now_req, logic old_req);
        return one_stage ? now_req : old_req;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ready=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(logic mode);
        @(posedge clk); #1;
        rst = 1'b1; rdy_a = 0; rdy_b = 0; en_a_n = 1; en_b_n = 1;
        two_stage_n = mode; // R8: strap only moves under reset
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #7;
            check("R7", ready, 1'b0);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        prev_req = 1'b0;
        last_rdy = 1'b0;
    endtask

    task automatic step(logic a, logic b, logic ea, logic eb);
        logic rq, ex;
        string tag;
        @(posedge clk); #1;
        rdy_a = a; rdy_b = b; en_a_n = ea; en_b_n = eb;
        #2;
        check("R6", ready, last_rdy);
        rq = ref_req(a, b, ea, eb);
        ex = ref_ready(two_stage_n, rq, prev_req);
        if (two_stage_n && ea && a && !(b && !eb)) tag = "R2";
        else if (two_stage_n && eb && b && !(a && !ea)) tag = "R3";
        else if (two_stage_n) tag = "R5/R1";
        else tag = "R4/R1";
        #4;
        check(tag, ready, ex);
        prev_req = rq;
        last_rdy = ex;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: ready=%b expected=finish", ready);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'h1A2B);
        // two-stage mode, directed
        do_reset(1'b0);
        step(1, 0, 0, 1);   // R1 via A
        step(0, 0, 1, 1);
        step(0, 1, 1, 0);   // R1 via B
        step(1, 1, 1, 1);   // both gated
        step(1, 1, 1, 1);
        for (int i = 0; i < 300; i++)
            step($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
        // one-stage mode, directed then random
        do_reset(1'b1);
        step(1, 0, 1, 1);   // R2 ignored
        step(0, 1, 0, 1);   // R3 ignored
        step(1, 0, 0, 1);
        step(0, 0, 0, 0);
        step(0, 1, 1, 0);
        for (int i = 0; i < 300; i++)
            step($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
        // back to two-stage to confirm strap follows reset (R8)
        do_reset(1'b0);
        step(1, 1, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule